// File: doc/BRIEF.md
# 12-bit Coefficient Byte Packer

This block turns polynomials of 12-bit coefficients into a dense byte stream. Every two adjacent coefficients become three bytes. It reads coefficients one at a time from a memory with a single registered read port. It writes the packed result one byte per cycle into a byte-wide memory with a single write port. One 256-coefficient polynomial therefore fills 384 bytes.

A controller loads a polynomial count of 2 to 4, a coefficient base address and a byte base address, then pulses start. The packer runs a fixed four-cycle schedule for each coefficient pair:

- the first cycle fetches the even coefficient;
- the second writes the first byte and fetches the odd coefficient;
- the third and fourth write the remaining two bytes.

Because reads and writes are interleaved this way, each memory needs only one port, and both can map onto plain block RAM. A one-cycle done pulse marks the end of the run.

Top module: `coef_byte_packer`

## Requirements
- R1: While reset is high and after it is released, with no start, `coef_re_o`, `byte_we_o` and `done_o` are all low.
- R2: For a pair with even coefficient c0 and odd coefficient c1, the three bytes written are:
  - first byte = c0 bits 7..0;
  - second byte = c1 bits 3..0 in bits 7..4 and c0 bits 11..8 in bits 3..0;
  - third byte = c1 bits 11..4.
- R3: Each pair takes four cycles with a fixed schedule:
  - cycle 0: fetch c0 only;
  - cycle 1: write the first byte and fetch c1;
  - cycle 2: write the second byte;
  - cycle 3: write the third byte.
  Read data is taken from `coef_rdata_i` in the cycle after the fetch. The first fetch occurs in the cycle after the start cycle.
- R4: Coefficient k of polynomial p is read from `coef_base + 256*p + k`. Its pair's bytes land at `byte_base + 384*p + 3*(k/2)` onward. No byte outside `byte_base .. byte_base + 384*n - 1` is written.
- R5: At most one byte is written per cycle. Consecutive write cycles use consecutive byte addresses, and every fetch is followed one cycle later by a write.
- R6: `done_o` is high for exactly one cycle, `512*n + 1` cycles after the start cycle, where n is the effective polynomial count. No fetch or write occurs in that cycle.
- R7: A `npoly_i` below 2 runs 2 polynomials, and one above 4 runs 4.
- R8: A start pulse, with any count or bases, while a run is in progress or in its done cycle, has no effect on the bytes written or the done timing.
- R9: The third byte depends only on the c1 value returned by its fetch. Any change of `coef_rdata_i` in cycles with no fetch pending leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| npoly_i | input | NPOLY_W (3) | Number of polynomials to pack |
| coef_base_i | input | CADDR_W (10) | Coefficient address of polynomial 0, coefficient 0 |
| byte_base_i | input | BADDR_W (11) | Byte address of the first output byte |
| coef_re_o | output | 1 | Coefficient read enable |
| coef_addr_o | output | CADDR_W (10) | Coefficient read address |
| coef_rdata_i | input | 12 | Registered read data, valid the cycle after a fetch |
| byte_we_o | output | 1 | Byte write enable |
| byte_addr_o | output | BADDR_W (11) | Byte write address |
| byte_data_o | output | 8 | Byte write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench packs the same memory image under four coefficient patterns, each probing a different fault:

- An arithmetic ramp gives every coefficient a distinct value, which exposes swapped pairs, skipped addresses and shifted nibbles.
- All-ones catches bits that are dropped or stuck low.
- Alternating all-zero and all-ones coefficients separates c0 bits from c1 bits in the shared middle byte.
- A multiplicative hash mixes both nibble halves.

The model memory returns unrelated data on cycles with no fetch, so a packer that reads late or does not hold the c1 bits writes a wrong third byte. Runs with counts 0, 2, 3, 4 and 7, with nonzero bases and with a start pulse in mid-run, cover the clamp, the offsets, the sentinel region and start rejection.

// File: rtl/pack_pkg.sv
package pack_pkg;
  localparam int COEF_W = 12;
  localparam int BYTE_W = 8;

  // Step within one coefficient pair; fixed 4-cycle schedule
  typedef enum logic [1:0] {
    PH_C0   = 2'd0,  // fetch even coefficient
    PH_B0C1 = 2'd1,  // write byte 0, fetch odd coefficient
    PH_B1   = 2'd2,  // write byte 1
    PH_B2   = 2'd3   // write byte 2
  } pack_ph_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } pack_st_e;
endpackage

// File: rtl/pack_seq.sv
module pack_seq
  import pack_pkg::*;
#(
  parameter int N_COEF   = 256,
  parameter int MIN_POLY = 2,
  parameter int MAX_POLY = 4,
  parameter int NPOLY_W  = 3,
  parameter int CADDR_W  = 10,
  parameter int BADDR_W  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [NPOLY_W-1:0] npoly_i,
  input  logic [CADDR_W-1:0] coef_base_i,
  input  logic [BADDR_W-1:0] byte_base_i,
  output logic               run_o,
  output pack_ph_e           ph_o,
  output logic [CADDR_W-1:0] coef_addr_o,
  output logic [BADDR_W-1:0] byte_addr_o,
  output logic               done_o
);
  localparam int PAIRS   = N_COEF / 2;
  localparam int TOT_MAX = MAX_POLY * PAIRS;
  localparam int PC_W    = $clog2(TOT_MAX + 1);

  pack_st_e           st;
  pack_ph_e           ph;
  logic [PC_W-1:0]    pair_cnt;
  logic [PC_W-1:0]    pair_last;
  logic [PC_W-1:0]    eff_n;
  logic [CADDR_W-1:0] cptr;
  logic [BADDR_W-1:0] bptr;

  // Clamp the requested count into the supported range
  always_comb begin
    if (npoly_i < NPOLY_W'(MIN_POLY))      eff_n = PC_W'(MIN_POLY);
    else if (npoly_i > NPOLY_W'(MAX_POLY)) eff_n = PC_W'(MAX_POLY);
    else                                   eff_n = PC_W'(npoly_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_C0;
      pair_cnt  <= '0;
      pair_last <= '0;
      cptr      <= '0;
      bptr      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            st        <= ST_RUN;
            ph        <= PH_C0;
            pair_cnt  <= '0;
            pair_last <= eff_n * PC_W'(PAIRS) - PC_W'(1);
            cptr      <= coef_base_i;
            bptr      <= byte_base_i;
          end
        end
        ST_RUN: begin
          ph <= pack_ph_e'(ph + 2'd1);
          if (ph == PH_C0 || ph == PH_B0C1) cptr <= cptr + CADDR_W'(1);
          if (ph != PH_C0)                  bptr <= bptr + BADDR_W'(1);
          if (ph == PH_B2) begin
            pair_cnt <= pair_cnt + PC_W'(1);
            if (pair_cnt == pair_last) st <= ST_FIN;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign run_o       = (st == ST_RUN);
  assign ph_o        = ph;
  assign coef_addr_o = cptr;
  assign byte_addr_o = bptr;
  assign done_o      = (st == ST_FIN);
endmodule

// File: rtl/pack_fmt.sv
module pack_fmt
  import pack_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  pack_ph_e          ph_i,
  input  logic [COEF_W-1:0] rdata_i,
  output logic [BYTE_W-1:0] byte_o
);
  // c0 high nibble outlives the read register, which c1 overwrites
  logic [3:0] c0_hi_r;
  // c1 upper byte is kept so the last write needs no further read
  logic [7:0] c1_hi_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      c0_hi_r <= '0;
      c1_hi_r <= '0;
    end else if (run_i) begin
      if (ph_i == PH_B0C1) c0_hi_r <= rdata_i[11:8];
      if (ph_i == PH_B1)   c1_hi_r <= rdata_i[11:4];
    end
  end

  always_comb begin
    unique case (ph_i)
      PH_B0C1: byte_o = rdata_i[7:0];
      PH_B1:   byte_o = {rdata_i[3:0], c0_hi_r};
      PH_B2:   byte_o = c1_hi_r;
      default: byte_o = '0;
    endcase
  end
endmodule

// File: rtl/coef_byte_packer.sv
module coef_byte_packer
  import pack_pkg::*;
#(
  parameter int N_COEF   = 256,
  parameter int MIN_POLY = 2,
  parameter int MAX_POLY = 4,
  parameter int NPOLY_W  = 3,
  parameter int CADDR_W  = 10,
  parameter int BADDR_W  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [NPOLY_W-1:0] npoly_i,
  input  logic [CADDR_W-1:0] coef_base_i,
  input  logic [BADDR_W-1:0] byte_base_i,
  output logic               coef_re_o,
  output logic [CADDR_W-1:0] coef_addr_o,
  input  logic [11:0]        coef_rdata_i,
  output logic               byte_we_o,
  output logic [BADDR_W-1:0] byte_addr_o,
  output logic [7:0]         byte_data_o,
  output logic               done_o
);
  logic     run;
  pack_ph_e ph;

  pack_seq #(
    .N_COEF(N_COEF), .MIN_POLY(MIN_POLY), .MAX_POLY(MAX_POLY),
    .NPOLY_W(NPOLY_W), .CADDR_W(CADDR_W), .BADDR_W(BADDR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .npoly_i(npoly_i),
    .coef_base_i(coef_base_i), .byte_base_i(byte_base_i),
    .run_o(run), .ph_o(ph), .coef_addr_o(coef_addr_o),
    .byte_addr_o(byte_addr_o), .done_o(done_o)
  );

  pack_fmt u_fmt (
    .clk(clk), .rst(rst), .run_i(run), .ph_i(ph),
    .rdata_i(coef_rdata_i), .byte_o(byte_data_o)
  );

  assign coef_re_o = run && (ph == PH_C0 || ph == PH_B0C1);
  assign byte_we_o = run && (ph != PH_C0);
endmodule

// File: rtl/coef_byte_packer_chk.sv
module coef_byte_packer_chk #(
  parameter int CADDR_W = 10,
  parameter int BADDR_W = 11
) (
  input logic               clk,
  input logic               rst,
  input logic               coef_re_o,
  input logic [CADDR_W-1:0] coef_addr_o,
  input logic               byte_we_o,
  input logic [BADDR_W-1:0] byte_addr_o,
  input logic               done_o
);
  // R5
  write_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    coef_re_o |=> byte_we_o);
  // R5
  byte_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_we_o && $past(byte_we_o)) |-> byte_addr_o == $past(byte_addr_o) + BADDR_W'(1));
  // R3
  fetch_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (coef_re_o && $past(coef_re_o)) |-> coef_addr_o == $past(coef_addr_o) + CADDR_W'(1));
  // R3
  no_third_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (coef_re_o && $past(coef_re_o)) |=> !coef_re_o);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!byte_we_o && !coef_re_o));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!byte_we_o && !coef_re_o && !done_o));
endmodule

bind coef_byte_packer coef_byte_packer_chk #(
  .CADDR_W(CADDR_W), .BADDR_W(BADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .coef_re_o(coef_re_o), .coef_addr_o(coef_addr_o),
  .byte_we_o(byte_we_o), .byte_addr_o(byte_addr_o), .done_o(done_o)
);

// File: tb/coef_byte_packer_bench.sv
module coef_byte_packer_bench;
  localparam int CADDR_W = 10;
  localparam int BADDR_W = 11;
  localparam int CDEPTH  = 1 << CADDR_W;
  localparam int BDEPTH  = 1 << BADDR_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start_i = 1'b0;
  logic [2:0]         npoly_i = '0;
  logic [CADDR_W-1:0] coef_base_i = '0;
  logic [BADDR_W-1:0] byte_base_i = '0;
  logic               coef_re_o;
  logic [CADDR_W-1:0] coef_addr_o;
  logic [11:0]        coef_rdata_i;
  logic               byte_we_o;
  logic [BADDR_W-1:0] byte_addr_o;
  logic [7:0]         byte_data_o;
  logic               done_o;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [11:0] cyc = '0;

  logic [11:0] cmem [CDEPTH];
  logic [7:0]  bmem [BDEPTH];

  always #4 clk = ~clk;

  coef_byte_packer u_coef_byte_packer (
    .clk(clk), .rst(rst), .start_i(start_i), .npoly_i(npoly_i),
    .coef_base_i(coef_base_i), .byte_base_i(byte_base_i),
    .coef_re_o(coef_re_o), .coef_addr_o(coef_addr_o), .coef_rdata_i(coef_rdata_i),
    .byte_we_o(byte_we_o), .byte_addr_o(byte_addr_o), .byte_data_o(byte_data_o),
    .done_o(done_o)
  );

  // Memory models: registered read returns junk when no fetch is made (R9)
  always @(posedge clk) begin
    cyc <= cyc + 12'd1;
    if (coef_re_o) coef_rdata_i <= cmem[coef_addr_o];
    else           coef_rdata_i <= 12'hC3A ^ (cyc * 12'd7);
    if (byte_we_o) begin
      bmem[byte_addr_o] <= byte_data_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pat(input int sel, input int idx);
    case (sel)
      0:       return 12'((idx * 37 + 5) & 12'hFFF);
      1:       return 12'hFFF;
      2:       return (idx % 2 == 1) ? 12'hFFF : 12'h000;
      default: return 12'(((idx * 2749) ^ 12'hA5C) & 12'hFFF);
    endcase
  endfunction

  // R2 layout computed from the pair values
  function automatic logic [7:0] exp_byte(input int sel, input int cb, input int off);
    int q = off / 3;
    logic [11:0] c0 = pat(sel, cb + 2 * q);
    logic [11:0] c1 = pat(sel, cb + 2 * q + 1);
    case (off % 3)
      0:       return c0[7:0];
      1:       return {c1[3:0], c0[11:8]};
      default: return c1[11:4];
    endcase
  endfunction

  task automatic run_case(input int np_in, input int eff, input int cb, input int bb,
                          input int sel, input bit midstart);
    int cnt = 0;
    int bad;
    int first_off;
    for (int i = 0; i < CDEPTH; i++) cmem[i] = pat(sel, i);
    for (int i = 0; i < BDEPTH; i++) bmem[i] = 8'hEE;
    @(negedge clk);
    wr_cnt = 0;
    npoly_i = 3'(np_in);
    coef_base_i = CADDR_W'(cb);
    byte_base_i = BADDR_W'(bb);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 1;
    while (!done_o && cnt < 4000) begin
      if (cnt == 1) // R3 fetch c0 only
        chk(coef_re_o && !byte_we_o && coef_addr_o == CADDR_W'(cb), "R3 cycle0", {coef_re_o, byte_we_o}, 2'b10);
      if (cnt == 2) // R3 write b0 and fetch c1
        chk(coef_re_o && byte_we_o && coef_addr_o == CADDR_W'(cb + 1) && byte_addr_o == BADDR_W'(bb),
            "R3 cycle1", int'(byte_addr_o), bb);
      if (cnt == 3 || cnt == 4) // R3 write-only cycles
        chk(!coef_re_o && byte_we_o && byte_addr_o == BADDR_W'(bb + cnt - 2), "R3 cycle2/3",
            int'(byte_addr_o), bb + cnt - 2);
      if (midstart && cnt == 60) begin
        npoly_i = 3'd2; coef_base_i = '0; byte_base_i = '0; start_i = 1'b1; // R8
      end
      if (midstart && cnt == 61) start_i = 1'b0;
      @(negedge clk);
      cnt++;
    end
    // R6 done timing, R7 effective count
    chk(cnt == 512 * eff + 1, "R6/R7 done cycle", cnt, 512 * eff + 1);
    if (midstart) begin
      start_i = 1'b1; // R8 start during done cycle is ignored
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(!done_o && !coef_re_o && !byte_we_o, "R6/R8 single pulse, idle after", {done_o, coef_re_o, byte_we_o}, 0);
    repeat (3) @(negedge clk);
    chk(!coef_re_o && !byte_we_o, "R8 no restart", {coef_re_o, byte_we_o}, 0);
    chk(wr_cnt == 384 * eff, "R5 write count", wr_cnt, 384 * eff);
    for (int p = 0; p < eff; p++) begin
      bad = 0;
      first_off = 0;
      for (int o = 0; o < 384; o++) begin
        if (bmem[bb + 384 * p + o] !== exp_byte(sel, cb + 256 * p, o)) begin
          if (bad == 0) first_off = o;
          bad++;
        end
      end
      // R2 R4 R9 byte contents per polynomial
      chk(bad == 0, $sformatf("R2/R4/R9 pat%0d poly%0d off%0d", sel, p, first_off),
          int'(bmem[bb + 384 * p + first_off]), int'(exp_byte(sel, cb + 256 * p, first_off)));
    end
    bad = 0;
    for (int i = 0; i < BDEPTH; i++)
      if ((i < bb || i >= bb + 384 * eff) && bmem[i] !== 8'hEE) bad++;
    chk(bad == 0, "R4 bytes outside region untouched", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 quiet in reset
    chk(!coef_re_o && !byte_we_o && !done_o, "R1 during reset", {coef_re_o, byte_we_o, done_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!coef_re_o && !byte_we_o && !done_o, "R1 after reset", {coef_re_o, byte_we_o, done_o}, 0);
    run_case(2, 2, 0,   0,   0, 1'b0);
    run_case(3, 3, 256, 100, 0, 1'b0);
    run_case(4, 4, 0,   512, 3, 1'b0);
    run_case(2, 2, 512, 7,   1, 1'b0);
    run_case(3, 3, 0,   300, 2, 1'b0);
    run_case(0, 2, 256, 33,  3, 1'b0); // R7 low clamp
    run_case(7, 4, 0,   1,   2, 1'b0); // R7 high clamp
    run_case(3, 3, 100, 200, 0, 1'b1); // R8 mid-run start
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule